// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a real-time clock and calendar. It shares one byte-wide address space with general-purpose RAM. The time is held as eight packed-BCD bytes: two digits per byte, the tens digit in the upper nibble and the units digit in the lower nibble. The bytes cover seconds, minutes, hours, day of week, date, month, year and century. They occupy the eight highest addresses. Every lower address reaches ordinary RAM. A single-cycle pulse on `tick_i`, once per second, advances the time. Carries run all the way from seconds to century, and the date follows month lengths and leap years.

The host uses a synchronous bus modelled on an asynchronous SRAM, with active-low chip enable, output enable and write enable. Control flags are packed into the spare top bits of the time bytes:
- an oscillator stop flag;
- a read flag that freezes a coherent copy of the time for multi-byte reads;
- a write flag that parks host-written time values and commits them as a group when it is cleared;
- a read-only battery-good indication;
- a frequency-test flag that drives a square wave onto `ftest_o`.

Top module: `rtc_bcd_mem`

## Requirements
- R1: The clock bytes sit at offsets 0 to 7 above 0x1FF8, in this order: control/century, seconds, minutes, hours, day, date, month, year. After reset the time is 00:00:00, day 01, date 01, month 01, year 00, century 00, and every control flag is 0.
- R2: A read cycle is ce_ni=0, oe_ni=0, we_ni=1. The addressed byte appears on rdata_o after the next rising clock edge. In any cycle that follows a non-read cycle, rdata_o is 0x00. A write cycle is ce_ni=0, we_ni=0.
- R3: Addresses below 0x1FF8 reach a RAM of 2^RAM_AW bytes. Address bits at and above RAM_AW are ignored there, so addresses that differ only in those bits alias to the same byte.
- R4: Counter rollovers: seconds wrap from 59 to 00 into minutes, minutes from 59 to 00 into hours, and hours from 23 to 00 into both date and day of week. Day of week wraps from 07 to 01.
- R5: Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30. February has 29 days when the BCD year taken as a decimal number is divisible by 4, and 28 days otherwise. Past the last day, the date goes to 01 and the month advances.
- R6: Month 12 wraps to 01 with a carry into year. Year 99 wraps to 00 with a carry into century. Century 39 wraps to 00.
- R7: Seconds byte bit 7 is the stop flag, writable at any time and read back in place. While it is 1, ticks change no time byte.
- R8: Control byte bit 7 is the write flag. Writes to time digits are taken only while the flag is already 1. While it is 1, reads return the parked values. A control-byte write that clears the flag loads all parked values into the counters. With the flag 0, digit writes have no effect.
- R9: Control byte bit 6 is the read flag. While it is 1, reads return the time as it stood when the flag was set, and the counters keep advancing underneath.
- R10: Unused bits are stored and read as 0. Digit masks: century 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF.
- R11: Day byte bit 7 always reads 1 and ignores writes.
- R12: Day byte bit 6 is the frequency-test flag, writable at any time. While it is 1, ftest_o toggles every FT_HALF clock cycles. While it is 0, ftest_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read cycle |
| ftest_o | output | 1 | Frequency-test square wave |

## Verification
Multi-level carries are the hardest cases to reach through the ports. A single tick must roll every byte from seconds to century, or take the date out of a short or leap February, and one second at a time that would take a simulated century. The stimulus therefore uses the write flag to park a chosen instant just before each boundary, commits it by clearing the flag, and then applies one tick. The read freeze and the write park are also checked while ticks keep arriving underneath, so that the value seen on the bus can be told apart from the live counters.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // byte offset within the clock window; the order is fixed by the address map
  localparam int unsigned IX_CEN  = 0;
  localparam int unsigned IX_SEC  = 1;
  localparam int unsigned IX_MIN  = 2;
  localparam int unsigned IX_HR   = 3;
  localparam int unsigned IX_DAY  = 4;
  localparam int unsigned IX_DATE = 5;
  localparam int unsigned IX_MON  = 6;
  localparam int unsigned IX_YR   = 7;

  typedef logic [7:0][7:0] rtc_regs_t;

  localparam rtc_regs_t RTC_RESET = 64'h00_01_01_01_00_00_00_00;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_wrap(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] base);
    return (v == top) ? base : bcd_inc(v);
  endfunction

  // decimal year divisible by 4, decided on the two BCD digits
  function automatic logic leap_yr(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                     return leap_yr(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] digit_mask(input logic [2:0] ix);
    case (ix)
      3'd0, 3'd3, 3'd5: return 8'h3F;
      3'd1, 3'd2:       return 8'h7F;
      3'd4:             return 8'h07;
      3'd6:             return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      run_i,
  input  logic      load_i,
  input  rtc_regs_t load_val_i,
  output rtc_regs_t time_o
);
  rtc_regs_t cur_q, nxt;
  logic      cy;
  logic [7:0] lday;

  always_comb begin
    nxt  = cur_q;
    cy   = 1'b1;
    lday = last_day(cur_q[IX_MON], cur_q[IX_YR]);
    nxt[IX_SEC] = bcd_wrap(cur_q[IX_SEC], 8'h59, 8'h00);
    cy = (cur_q[IX_SEC] == 8'h59);
    if (cy) begin
      nxt[IX_MIN] = bcd_wrap(cur_q[IX_MIN], 8'h59, 8'h00);
      cy = (cur_q[IX_MIN] == 8'h59);
    end
    if (cy) begin
      nxt[IX_HR] = bcd_wrap(cur_q[IX_HR], 8'h23, 8'h00);
      cy = (cur_q[IX_HR] == 8'h23);
    end
    if (cy) begin
      nxt[IX_DAY]  = bcd_wrap(cur_q[IX_DAY], 8'h07, 8'h01);
      nxt[IX_DATE] = bcd_wrap(cur_q[IX_DATE], lday, 8'h01);
      cy = (cur_q[IX_DATE] == lday);
    end
    if (cy) begin
      nxt[IX_MON] = bcd_wrap(cur_q[IX_MON], 8'h12, 8'h01);
      cy = (cur_q[IX_MON] == 8'h12);
    end
    if (cy) begin
      nxt[IX_YR] = bcd_wrap(cur_q[IX_YR], 8'h99, 8'h00);
      cy = (cur_q[IX_YR] == 8'h99);
    end
    if (cy) nxt[IX_CEN] = bcd_wrap(cur_q[IX_CEN], 8'h39, 8'h00);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cur_q <= RTC_RESET;
    else if (load_i)            cur_q <= load_val_i;
    else if (tick_i && run_i)   cur_q <= nxt;
  end

  assign time_o = cur_q;
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/rtc_ftest.sv
module rtc_ftest #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wave_o
);
  localparam int unsigned CW = (HALF > 2) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_q  <= '0;
      wave_o <= ~wave_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bcd_mem.sv
module rtc_bcd_mem
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned RAM_AW  = 10,
  parameter int unsigned FT_HALF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ftest_o
);
  logic       rd_cyc, wr_cyc, is_clk, clk_wr, load;
  logic [2:0] idx;
  logic       st_q, ft_q, w_q, r_q;
  rtc_regs_t  live, hold_q, hold_wr, snap_q, src;
  logic [7:0] clk_byte, clk_rd_q, ram_rd;
  logic       rd_q, sel_clk_q;

  assign rd_cyc = !ce_ni && !oe_ni && we_ni;
  assign wr_cyc = !ce_ni && !we_ni;
  assign is_clk = &addr_i[ADDR_W-1:3];
  assign idx    = addr_i[2:0];
  assign clk_wr = wr_cyc && is_clk;
  // commit happens on the control write that drops the write flag
  assign load   = clk_wr && (idx == 3'd0) && w_q && !wdata_i[7];

  always_comb begin
    hold_wr = hold_q;
    if (clk_wr) hold_wr[idx] = wdata_i & digit_mask(idx);
  end

  rtc_time_chain u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (!st_q),
    .load_i     (load),
    .load_val_i (hold_wr),
    .time_o     (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= 1'b0;
      ft_q   <= 1'b0;
      w_q    <= 1'b0;
      r_q    <= 1'b0;
      hold_q <= RTC_RESET;
      snap_q <= RTC_RESET;
    end else begin
      hold_q <= w_q ? hold_wr : live;
      if (!r_q) snap_q <= live;
      if (clk_wr) begin
        case (idx)
          3'd0: begin
            w_q <= wdata_i[7];
            r_q <= wdata_i[6];
          end
          3'd1: st_q <= wdata_i[7];
          3'd4: ft_q <= wdata_i[6];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    src      = w_q ? hold_q : (r_q ? snap_q : live);
    clk_byte = src[idx];
    case (idx)
      3'd0: clk_byte = {w_q, r_q, clk_byte[5:0]};
      3'd1: clk_byte = {st_q, clk_byte[6:0]};
      3'd4: clk_byte = {1'b1, ft_q, clk_byte[5:0]};
      default: ;
    endcase
  end

  rtc_ram #(.AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_cyc && !is_clk),
    .re_i    (rd_cyc && !is_clk),
    .addr_i  (addr_i[RAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      sel_clk_q <= 1'b0;
      clk_rd_q  <= 8'h00;
    end else begin
      rd_q      <= rd_cyc;
      sel_clk_q <= is_clk;
      if (rd_cyc && is_clk) clk_rd_q <= clk_byte;
    end
  end

  assign rdata_o = !rd_q ? 8'h00 : (sel_clk_q ? clk_rd_q : ram_rd);

  rtc_ftest #(.HALF(FT_HALF)) u_ftest (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ft_q),
    .wave_o (ftest_o)
  );
endmodule

// File: rtl/rtc_bcd_mem_chk.sv
module rtc_bcd_mem_chk
  import rtc_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tick_i,
  input logic      ce_ni,
  input logic      oe_ni,
  input logic      we_ni,
  input logic [7:0] rdata_i,
  input logic      ftest_i,
  input logic      st_i,
  input logic      ft_i,
  input logic      load_i,
  input rtc_regs_t live_i
);
  // R7
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i && !load_i) |=> $stable(live_i));

  // R4
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !st_i && !load_i && live_i[IX_SEC][3:0] != 4'd9)
      |=> live_i[IX_SEC] == $past(live_i[IX_SEC]) + 8'd1);

  // R4
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (live_i[IX_SEC][3:0] <= 4'd9 && live_i[IX_SEC][7:4] <= 4'd5));

  // R4
  day_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (live_i[IX_DAY] >= 8'h01 && live_i[IX_DAY] <= 8'h07));

  // R5
  date_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (live_i[IX_DATE] >= 8'h01 && live_i[IX_DATE] <= 8'h31));

  // R2
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_ni && !oe_ni && we_ni) |=> rdata_i == 8'h00);

  // R12
  ft_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ft_i && $past(!ft_i)) |-> !ftest_i);
endmodule

bind rtc_bcd_mem rtc_bcd_mem_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .ce_ni   (ce_ni),
  .oe_ni   (oe_ni),
  .we_ni   (we_ni),
  .rdata_i (rdata_o),
  .ftest_i (ftest_o),
  .st_i    (st_q),
  .ft_i    (ft_q),
  .load_i  (load),
  .live_i  (live)
);

// File: tb/tb_rtc_bcd_mem.sv
module tb_rtc_bcd_mem;
  localparam int unsigned ADDR_W  = 13;
  localparam int unsigned FT_HALF = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = 8'h00;
  logic [7:0]        rdata_o;
  logic              ftest_o;

  rtc_bcd_mem #(.ADDR_W(ADDR_W), .RAM_AW(10), .FT_HALF(FT_HALF)) dut (
    .clk_i, .rst_ni, .tick_i, .ce_ni, .oe_ni, .we_ni, .addr_i, .wdata_i, .rdata_o, .ftest_o
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [7:0] exp;
    logic [12:0] addr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic rd_issued = 1'b0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk_i);
    ce_ni = 1'b0; we_ni = 1'b0; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    ce_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] exp, input string tag);
    exp_t it;
    @(negedge clk_i);
    ce_ni = 1'b0; oe_ni = 1'b0; addr_i = a;
    it.exp = exp; it.addr = a; it.tag = tag;
    q.push_back(it);
    rd_issued = 1'b1;
    @(negedge clk_i);
    ce_ni = 1'b1; oe_ni = 1'b1;
    rd_issued = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  // park via the write flag, then commit; century byte drops the flag
  task automatic set_time(input logic [7:0] s, mi, h, dy, dt, mo, y, c);
    wr(13'h1FF8, 8'h80);
    wr(13'h1FF9, s);  wr(13'h1FFA, mi); wr(13'h1FFB, h);  wr(13'h1FFC, dy);
    wr(13'h1FFD, dt); wr(13'h1FFE, mo); wr(13'h1FFF, y);
    wr(13'h1FF8, c);
  endtask

  // monitor: a read applied before this edge is compared after it
  initial begin
    forever begin
      logic pend;
      @(posedge clk_i);
      pend = rd_issued;
      #2;
      if (pend && q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_chk++;
        if (rdata_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s @%04h: got %02h expected %02h", it.tag, it.addr, rdata_o, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi;
    bit seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state and map order
    rd(13'h1FF8, 8'h00, "R1 ctrl");
    rd(13'h1FF9, 8'h00, "R1 sec");
    rd(13'h1FFB, 8'h00, "R1 hour");
    rd(13'h1FFC, 8'h81, "R1 day");
    rd(13'h1FFD, 8'h01, "R1 date");
    rd(13'h1FFE, 8'h01, "R1 month");
    rd(13'h1FFF, 8'h00, "R1 year");

    // R2 no read -> zero
    @(negedge clk_i); @(negedge clk_i);
    check(rdata_o == 8'h00, "R2 idle rdata", rdata_o, 8'h00);

    // R3 RAM and aliasing
    wr(13'h0123, 8'h5A);
    rd(13'h0123, 8'h5A, "R3 ram");
    wr(13'h1FF7, 8'hA5);
    rd(13'h1FF7, 8'hA5, "R3 ram top");
    rd(13'h03F7, 8'hA5, "R3 ram alias");

    // R4 minute carry
    set_time(8'h59, 8'h09, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24, 8'h20);
    tick_n(1);
    rd(13'h1FF9, 8'h00, "R4 sec wrap");
    rd(13'h1FFA, 8'h10, "R4 min carry");
    rd(13'h1FFB, 8'h10, "R4 hour kept");

    // R4 R6 full carry chain
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h39);
    rd(13'h1FF9, 8'h59, "R8 loaded sec");
    tick_n(1);
    rd(13'h1FF8, 8'h00, "R6 century wrap");
    rd(13'h1FF9, 8'h00, "R4 sec");
    rd(13'h1FFA, 8'h00, "R4 min");
    rd(13'h1FFB, 8'h00, "R4 hour wrap");
    rd(13'h1FFC, 8'h81, "R4 day 7->1");
    rd(13'h1FFD, 8'h01, "R5 date wrap");
    rd(13'h1FFE, 8'h01, "R6 month wrap");
    rd(13'h1FFF, 8'h00, "R6 year wrap");

    // R5 month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 8'h20);
    tick_n(1);
    rd(13'h1FFD, 8'h29, "R5 leap feb 29");
    rd(13'h1FFE, 8'h02, "R5 leap month");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24, 8'h20);
    tick_n(1);
    rd(13'h1FFD, 8'h01, "R5 leap end");
    rd(13'h1FFE, 8'h03, "R5 march");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20);
    tick_n(1);
    rd(13'h1FFD, 8'h01, "R5 common feb");
    rd(13'h1FFE, 8'h03, "R5 common march");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23, 8'h20);
    tick_n(1);
    rd(13'h1FFD, 8'h01, "R5 april end");
    rd(13'h1FFE, 8'h05, "R5 may");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h23, 8'h20);
    tick_n(1);
    rd(13'h1FFD, 8'h31, "R5 jan 31");
    rd(13'h1FFC, 8'h83, "R4 day step");

    // R7 stop flag
    set_time(8'h10, 8'h05, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24, 8'h20);
    wr(13'h1FF9, 8'hC5);
    rd(13'h1FF9, 8'h90, "R7 stop set");
    tick_n(3);
    rd(13'h1FF9, 8'h90, "R7 stopped");
    wr(13'h1FF9, 8'h00);
    rd(13'h1FF9, 8'h10, "R7 stop clear");
    tick_n(1);
    rd(13'h1FF9, 8'h11, "R7 running");

    // R8 write flag
    wr(13'h1FFA, 8'h33);
    rd(13'h1FFA, 8'h05, "R8 write ignored");
    wr(13'h1FF8, 8'h80);
    tick_n(2);
    rd(13'h1FF9, 8'h11, "R8 parked read");
    wr(13'h1FF9, 8'h42);
    rd(13'h1FF9, 8'h42, "R8 parked write");
    wr(13'h1FF8, 8'h20);
    rd(13'h1FF9, 8'h42, "R8 committed");
    rd(13'h1FF8, 8'h20, "R8 ctrl");
    rd(13'h1FFA, 8'h05, "R8 min kept");

    // R9 read freeze
    wr(13'h1FF8, 8'h60);
    rd(13'h1FF8, 8'h60, "R9 flag");
    tick_n(3);
    rd(13'h1FF9, 8'h42, "R9 frozen");
    wr(13'h1FF8, 8'h00);
    rd(13'h1FF9, 8'h45, "R9 counted on");
    rd(13'h1FF8, 8'h20, "R9 century kept");

    // R10 masks
    wr(13'h1FF8, 8'h80);
    wr(13'h1FFB, 8'hFF);
    rd(13'h1FFB, 8'h3F, "R10 hour mask");
    wr(13'h1FFE, 8'hFF);
    rd(13'h1FFE, 8'h1F, "R10 month mask");
    wr(13'h1FFB, 8'h10);
    wr(13'h1FFE, 8'h06);
    wr(13'h1FF8, 8'h20);
    rd(13'h1FFB, 8'h10, "R10 hour restored");

    // R11 battery flag
    wr(13'h1FFC, 8'h05);
    rd(13'h1FFC, 8'h83, "R11 flag stays");

    // R12 frequency test
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(ftest_o == 1'b0, "R12 idle low", {7'd0, ftest_o}, 8'h00);
    end
    wr(13'h1FFC, 8'h40);
    rd(13'h1FFC, 8'hC3, "R12 flag");
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk_i);
      if (ftest_o) seen = 1;
    end
    hi = seen ? 1 : 0;
    for (int i = 0; i < 20 && seen; i++) begin
      @(negedge clk_i);
      if (ftest_o) hi++;
      else seen = 0;
    end
    check(hi == FT_HALF, "R12 high time", 8'(hi), 8'(FT_HALF));
    wr(13'h1FFC, 8'h00);
    repeat (2) @(negedge clk_i);
    check(ftest_o == 1'b0, "R12 off", {7'd0, ftest_o}, 8'h00);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule